// File: doc/BRIEF.md
# Watchdog Overflow Reset Controller

This block combines an 8-bit watchdog counter with a status register that decides how a counter overflow is handled. Software reaches three byte-wide registers over a small read/write bus: the counter, a run-control register and the status register. A clock-enable input advances the counter. A mode input selects how an overflow is treated. In watchdog mode an overflow latches a sticky flag, stops and clears the counter, and can request an internal reset. In interval mode an overflow raises a one-cycle interrupt and the counter keeps running.

The flag is cleared through a two-step handshake held in a small state machine. The machine has two states, `CLR_IDLE` and `CLR_ARMED`. Transition *arm* goes from `CLR_IDLE` to `CLR_ARMED` when the status register is read while the flag is 1. Transition *consume* goes from `CLR_ARMED` back to `CLR_IDLE` on any write to the status register. Only a write made in `CLR_ARMED` with data bit 7 at 0 clears the flag. Transition *init* forces `CLR_IDLE` on pin reset or on a standby reset. The internal reset request that the block produces does not touch the status register, so software can still see why the reset happened.

Top module: `wdt_ovf_rst_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released, the status register (address 2) reads 0x1F, the counter (address 0) and the control register (address 1) read 0x00, and `rst_req` and `ivl_irq` are low.
- R2: The counter adds one on each clock with `tick_en` high while control bit 0 (run) is 1, and wraps from 0xFF to 0x00. It holds while run is 0. A bus write to address 0 loads it.
- R3: Status bit 7 (the overflow flag) becomes 1 on a counter overflow in watchdog mode (`wd_mode`=1). An overflow in interval mode (`wd_mode`=0) never sets it.
- R4: The flag is cleared only by a status write with data bit 7 at 0 that follows a status read that returned bit 7 as 1. Such a write with no prior read leaves the flag at 1.
- R5: Any status write drops the armed state, including a write with bit 7 at 1, which does not clear the flag. A later write of 0 then has no effect until the flag is read again.
- R6: If a watchdog-mode overflow occurs in the same cycle as a valid clearing write, the flag remains 1.
- R7: With status bit 6 (reset enable) at 1, a watchdog-mode overflow gives `rst_req` high for exactly one cycle, starting the cycle after the overflow. With bit 6 at 0, `rst_req` stays low.
- R8: A watchdog-mode overflow clears the counter to 0x00 and the control register to 0x00, whatever the value of bit 6, so further ticks do not count.
- R9: A watchdog-mode overflow leaves status bits 6 and 5 unchanged.
- R10: A one-cycle `stby_rst` pulse returns the status register to 0x1F and the counter and control register to 0x00.
- R11: Status bit 5 reads back what was written and has no effect. Bits 4..0 always read 1 and ignore writes. Address 3 reads 0x00.
- R12: An interval-mode overflow gives `ivl_irq` high for one cycle, starting the cycle after the overflow. The counter continues from 0x00 with run still 1, and `rst_req` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low pin reset |
| stby_rst | input | 1 | Synchronous standby reset, active high |
| tick_en | input | 1 | Counter advance enable |
| wd_mode | input | 1 | 1 = watchdog mode, 0 = interval mode |
| bus_addr | input | 2 | Register select: 0 counter, 1 control, 2 status |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| rst_req | output | 1 | Internal reset request pulse |
| ivl_irq | output | 1 | Interval overflow interrupt pulse |

## Verification
The hardest case to reach from the ports is an overflow landing in the same cycle as an armed clearing write. The bench first arms the handshake with a status read. It then parks the counter at 0xFF with run set. In one cycle it drives `tick_en` together with the status write of 0. The flag must survive. Another directed sequence covers the handshake ordering: a write without a read, and a write of 1 that uses up the arming. A seeded random phase then runs bursts of ticks in interval mode and checks the counter value and the interrupt count against bench arithmetic.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int DW = 8;
    localparam int AW = 2;

    localparam logic [AW-1:0] A_CNT  = 2'd0;
    localparam logic [AW-1:0] A_CTL  = 2'd1;
    localparam logic [AW-1:0] A_STAT = 2'd2;

    localparam logic [DW-1:0] STAT_INIT = 8'h1F;

    typedef enum logic [0:0] {
        CLR_IDLE  = 1'b0,
        CLR_ARMED = 1'b1
    } clr_state_e;
endpackage

// File: rtl/wdt_tick_counter.sv
module wdt_tick_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         stby,
    input  logic         tick,
    input  logic         wd_mode,
    input  logic         cnt_we,
    input  logic         ctl_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] cnt,
    output logic         run,
    output logic         ovf
);
    assign ovf = tick && run && (&cnt);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            run <= 1'b0;
        end else if (stby) begin
            cnt <= '0;
            run <= 1'b0;
        end else if (ovf && wd_mode) begin
            cnt <= '0;
            run <= 1'b0;
        end else begin
            if (cnt_we)
                cnt <= wdata;
            else if (tick && run)
                cnt <= cnt + W'(1);
            if (ctl_we)
                run <= wdata[0];
        end
    end

    // R8: watchdog overflow wipes counter and run bit
    a_r8_wd_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && wd_mode) |=> (cnt == '0 && !run));

    // R2: plain tick advances by one, wrapping
    a_r2_increment: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && run && !cnt_we && !stby && !wd_mode) |=> (cnt == $past(cnt) + W'(1)));
endmodule

// File: rtl/wdt_status_ctl.sv
module wdt_status_ctl
    import wdt_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stby,
    input  logic          rd_stat,
    input  logic          wr_stat,
    input  logic [2:0]    wbits,
    input  logic          ovf_wd,
    output logic [DW-1:0] stat,
    output logic          rst_en
);
    clr_state_e state_q, state_d;
    logic flag_q, spare_q, clr_ok;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= CLR_IDLE;
        else if (stby)
            state_q <= CLR_IDLE;
        else
            state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CLR_IDLE:  if (rd_stat && flag_q) state_d = CLR_ARMED;
            CLR_ARMED: if (wr_stat)           state_d = CLR_IDLE;
        endcase
    end

    // outputs of the handshake
    always_comb begin
        clr_ok = 1'b0;
        unique case (state_q)
            CLR_IDLE:  clr_ok = 1'b0;
            CLR_ARMED: clr_ok = wr_stat && !wbits[2];
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q  <= STAT_INIT[7];
            rst_en  <= STAT_INIT[6];
            spare_q <= STAT_INIT[5];
        end else if (stby) begin
            flag_q  <= STAT_INIT[7];
            rst_en  <= STAT_INIT[6];
            spare_q <= STAT_INIT[5];
        end else begin
            if (ovf_wd)
                flag_q <= 1'b1;
            else if (clr_ok)
                flag_q <= 1'b0;
            if (wr_stat) begin
                rst_en  <= wbits[1];
                spare_q <= wbits[0];
            end
        end
    end

    assign stat = {flag_q, rst_en, spare_q, STAT_INIT[4:0]};

    // R3: flag only rises after a watchdog overflow
    a_r3_flag_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(ovf_wd));

    // R4: flag only falls on an armed zero write or a standby reset
    a_r4_flag_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_q) |-> $past(stby || (wr_stat && !wbits[2] && state_q == CLR_ARMED)));

    // R6: overflow always leaves the flag set
    a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_wd && !stby) |=> flag_q);

    // R5: any status write leaves the handshake idle
    a_r5_consume: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && state_q == CLR_ARMED) |=> (state_q == CLR_IDLE));
endmodule

// File: rtl/wdt_ovf_rst_ctrl.sv
module wdt_ovf_rst_ctrl
    import wdt_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stby_rst,
    input  logic          tick_en,
    input  logic          wd_mode,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_rd,
    input  logic          bus_wr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          rst_req,
    output logic          ivl_irq
);
    logic [DW-1:0] cnt, stat;
    logic run, ovf, ovf_wd, ovf_iv, rst_en;

    assign ovf_wd = ovf && wd_mode;
    assign ovf_iv = ovf && !wd_mode;

    wdt_tick_counter #(.W(DW)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .stby    (stby_rst),
        .tick    (tick_en),
        .wd_mode (wd_mode),
        .cnt_we  (bus_wr && bus_addr == A_CNT),
        .ctl_we  (bus_wr && bus_addr == A_CTL),
        .wdata   (bus_wdata),
        .cnt     (cnt),
        .run     (run),
        .ovf     (ovf)
    );

    wdt_status_ctl u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .stby    (stby_rst),
        .rd_stat (bus_rd && bus_addr == A_STAT),
        .wr_stat (bus_wr && bus_addr == A_STAT),
        .wbits   (bus_wdata[7:5]),
        .ovf_wd  (ovf_wd),
        .stat    (stat),
        .rst_en  (rst_en)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_req <= 1'b0;
            ivl_irq <= 1'b0;
        end else if (stby_rst) begin
            rst_req <= 1'b0;
            ivl_irq <= 1'b0;
        end else begin
            rst_req <= ovf_wd && rst_en;
            ivl_irq <= ovf_iv;
        end
    end

    always_comb begin
        unique case (bus_addr)
            A_CNT:   bus_rdata = cnt;
            A_CTL:   bus_rdata = {{(DW-1){1'b0}}, run};
            A_STAT:  bus_rdata = stat;
            default: bus_rdata = '0;
        endcase
    end

    // R7: reset request follows an enabled watchdog overflow
    a_r7_rst_cause: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> $past(ovf_wd && rst_en));

    // R7: reset request lasts one cycle
    a_r7_rst_single: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    // R12: interval interrupt never coincides with a reset request
    a_r12_irq_excl: assert property (@(posedge clk) disable iff (!rst_n)
        ivl_irq |-> !rst_req);
endmodule

// File: tb/tb_wdt_ovf_rst_ctrl.sv
module tb_wdt_ovf_rst_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stby_rst = 1'b0;
    logic       tick_en = 1'b0;
    logic       wd_mode = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       rst_req, ivl_irq;

    int checks = 0;
    int fails = 0;
    int rst_pulses = 0, irq_pulses = 0;
    int rst_run = 0, rst_max = 0, irq_run = 0, irq_max = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    wdt_ovf_rst_ctrl dut (
        .clk(clk), .rst_n(rst_n), .stby_rst(stby_rst), .tick_en(tick_en),
        .wd_mode(wd_mode), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rst_req(rst_req), .ivl_irq(ivl_irq)
    );

    always @(negedge clk) begin
        if (rst_req) begin
            if (rst_run == 0) rst_pulses++;
            rst_run++;
            if (rst_run > rst_max) rst_max = rst_run;
        end else rst_run = 0;
        if (ivl_irq) begin
            if (irq_run == 0) irq_pulses++;
            irq_run++;
            if (irq_run > irq_max) irq_max = irq_run;
        end else irq_run = 0;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input int act, input int exp);
        check(act == exp, req, act, exp);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic ticks(input int n);
        if (n > 0) begin
            @(negedge clk);
            tick_en = 1'b1;
            repeat (n) @(negedge clk);
            tick_en = 1'b0;
        end
    endtask

    function automatic int exp_count(input int start, input int n);
        return (start + n) % 256;
    endfunction

    function automatic int exp_wraps(input int start, input int n);
        return (start + n) / 256;
    endfunction

    initial begin
        #(8 * 200000);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        int r0, i0, seed;
        seed = $urandom(32'h5EED_0042);

        // R1: reset state
        repeat (3) @(negedge clk);
        rd(2'd2, d); chk_eq("R1 status during reset", d, 8'h1F);
        rst_n = 1'b1;
        rd(2'd2, d); chk_eq("R1 status", d, 8'h1F);
        rd(2'd0, d); chk_eq("R1 counter", d, 8'h00);
        rd(2'd1, d); chk_eq("R1 control", d, 8'h00);
        chk_eq("R1 rst_req", rst_req, 0);
        chk_eq("R1 ivl_irq", ivl_irq, 0);

        // R11: reserved and fixed bits
        wr(2'd2, 8'hFF); rd(2'd2, d); chk_eq("R11 write ones", d, 8'h7F);
        wr(2'd2, 8'h00); rd(2'd2, d); chk_eq("R11 write zeros", d, 8'h1F);
        rd(2'd3, d); chk_eq("R11 unused address", d, 8'h00);

        // R2: counting and holding
        wd_mode = 1'b0;
        wr(2'd0, 8'h10); wr(2'd1, 8'h01);
        ticks(5); rd(2'd0, d); chk_eq("R2 count five", d, 8'h15);
        wr(2'd1, 8'h00); ticks(3); rd(2'd0, d); chk_eq("R2 hold when stopped", d, 8'h15);

        // R12 / R3: interval overflow
        wr(2'd2, 8'h40);
        r0 = rst_pulses; i0 = irq_pulses;
        wr(2'd0, 8'hFE); wr(2'd1, 8'h01);
        ticks(3);
        rd(2'd0, d); chk_eq("R12 counter continues", d, 8'h01);
        rd(2'd1, d); chk_eq("R12 run kept", d, 8'h01);
        chk_eq("R12 irq pulses", irq_pulses - i0, 1);
        chk_eq("R12 irq width", irq_max, 1);
        chk_eq("R12 no reset request", rst_pulses - r0, 0);
        rd(2'd2, d); chk_eq("R3 interval leaves flag", d, 8'h5F);

        // R7 / R8 / R9: watchdog overflow with reset enabled
        wd_mode = 1'b1;
        wr(2'd2, 8'h60);
        r0 = rst_pulses;
        wr(2'd0, 8'hFD); wr(2'd1, 8'h01);
        ticks(4);
        chk_eq("R7 one reset pulse", rst_pulses - r0, 1);
        chk_eq("R7 pulse width", rst_max, 1);
        rd(2'd0, d); chk_eq("R8 counter cleared", d, 8'h00);
        rd(2'd1, d); chk_eq("R8 control cleared", d, 8'h00);

        // R4 / R5: clear handshake
        wr(2'd2, 8'h60);
        rd(2'd2, d); chk_eq("R4 write without read ignored / R9 bits kept", d, 8'hFF);
        wr(2'd2, 8'hE0);
        wr(2'd2, 8'h60);
        rd(2'd2, d); chk_eq("R5 arming consumed by write of 1", d, 8'hFF);
        wr(2'd2, 8'h60);
        rd(2'd2, d); chk_eq("R4 armed clear", d, 8'h7F);

        // R7 / R8 / R9 / R3: reset enable off
        wr(2'd2, 8'h20);
        r0 = rst_pulses;
        wr(2'd0, 8'hFE); wr(2'd1, 8'h01);
        ticks(2);
        chk_eq("R7 no pulse when disabled", rst_pulses - r0, 0);
        rd(2'd0, d); chk_eq("R8 counter cleared, enable off", d, 8'h00);
        rd(2'd1, d); chk_eq("R8 control cleared, enable off", d, 8'h00);
        rd(2'd2, d); chk_eq("R3 flag set / R9 bits kept", d, 8'hBF);

        // R6: overflow coincides with an armed clearing write
        wr(2'd0, 8'hFF); wr(2'd1, 8'h01);
        @(negedge clk);
        bus_addr = 2'd2; bus_wdata = 8'h20; bus_wr = 1'b1; tick_en = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; tick_en = 1'b0;
        rd(2'd2, d); chk_eq("R6 set wins over clear", d, 8'hBF);

        // R10: standby reset
        wr(2'd1, 8'h01); wr(2'd0, 8'h33);
        @(negedge clk); stby_rst = 1'b1;
        @(negedge clk); stby_rst = 1'b0;
        rd(2'd2, d); chk_eq("R10 status", d, 8'h1F);
        rd(2'd0, d); chk_eq("R10 counter", d, 8'h00);
        rd(2'd1, d); chk_eq("R10 control", d, 8'h00);

        // R2 / R12 / R3: seeded random bursts in interval mode
        wd_mode = 1'b0;
        for (int it = 0; it < 60; it++) begin
            int start, n;
            start = $urandom % 256;
            n = $urandom % 300;
            wr(2'd2, ($urandom % 2) ? 8'h40 : 8'h00);
            wr(2'd0, start[7:0]); wr(2'd1, 8'h01);
            r0 = rst_pulses; i0 = irq_pulses;
            ticks(n);
            rd(2'd0, d); chk_eq("R2 random count", d, exp_count(start, n));
            chk_eq("R12 random irq count", irq_pulses - i0, exp_wraps(start, n));
            chk_eq("R12 random no reset", rst_pulses - r0, 0);
            rd(2'd2, d); chk_eq("R3 random flag clear", d[7], 0);
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule